// File: doc/BRIEF.md
# Aspect-Configurable Dual-Port RAM Block

This block holds a fixed array of 256 storage bits behind one write port and one read port, each on its own clock. A static mode input chooses how the array appears to the user: either 32 words of 8 bits or 64 words of 4 bits. In the narrow organisation the lowest address bit selects one half of an 8-bit physical row. A write changes only that half. A read returns that half in the low bits of the read data, with zeros above it.

Each block has a fixed position, set by a parameter. A write select input and a read select input are compared against that position. The block stores data only when the write select matches. When a read is made with a read select that does not match, the read output returns zero. This lets several blocks share an address bus and have their read outputs combined with a plain OR, which builds deeper memories. Placing blocks side by side with shared addresses builds wider ones.

Reads are registered on the read clock. A read and a write to the same location on the same edge return the contents as they were before the write.

Top module: `aspect_dpram`

## Requirements
- R1: While `rd_rst_n` is low, and after it is released, `rd_data` is zero until the first enabled read.
- R2: With `wide_mode`=1 (32x8), a write stores all 8 bits of `wr_data` at row `wr_addr[4:0]`, and a later read of `rd_addr[4:0]` returns those bits. Address bit 5 is ignored in this mode.
- R3: With `wide_mode`=0 (64x4), a write stores only `wr_data[3:0]`. A read returns the stored nibble on `rd_data[3:0]` with `rd_data[7:4]`=0. The other nibble of the same row is unchanged by the write.
- R4: Narrow address 2k+n refers to row k: n=0 selects bits [3:0] of that row and n=1 selects bits [7:4], on both ports. Data written in one mode can therefore be read in the other.
- R5: Read data appears on the first `rd_clk` rising edge after the edge on which `rd_en` is sampled high. While `rd_en` is low, `rd_data` holds its value.
- R6: When a read and a write address the same location on the same clock edge, the read returns the contents from before the write.
- R7: A write with `wr_sel` different from parameter `BLOCK_ID` changes no stored bit.
- R8: An enabled read with `rd_sel` different from `BLOCK_ID` makes `rd_data` zero on the next edge.
- R9: With `wr_en` low, no stored bit changes.
- R10: All 32 wide rows and all 64 narrow nibbles are distinct locations, which gives exactly 256 bits of storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| wr_en | input | 1 | Write request |
| wr_sel | input | SEL_W | Write block select, compared with BLOCK_ID |
| wr_addr | input | 6 | Write address |
| wr_data | input | 8 | Write data (low nibble only in narrow mode) |
| rd_clk | input | 1 | Read port clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset of the read register |
| rd_en | input | 1 | Read request |
| rd_sel | input | SEL_W | Read block select, compared with BLOCK_ID |
| rd_addr | input | 6 | Read address |
| rd_data | output | 8 | Registered read data, zero when deselected |
| wide_mode | input | 1 | Organisation: 1 = 32x8, 0 = 64x4 |

## Verification
The assertions check four properties on every cycle. Read data holds while no read is requested. A deselected read yields zero. The upper nibble is zero after a narrow read. Write lane enables stay silent for a mismatched select and are at most one-hot in narrow mode. Stored contents can only be seen through later reads, so the bench scenarios are what show the following: the data round trip in each mode, the nibble layout across modes, old-data return on a same-edge collision, that ignored writes leave the array intact, and that all 256 bits are distinct.

// File: rtl/aspect_dpram_pkg.sv
`timescale 1ns/1ps
package aspect_dpram_pkg;
  typedef enum logic {
    ORG_NARROW = 1'b0,
    ORG_WIDE   = 1'b1
  } org_e;

  localparam int unsigned LANES = 2;
endpackage

// File: rtl/aspect_dpram_amap.sv
`timescale 1ns/1ps
module aspect_dpram_amap
  import aspect_dpram_pkg::*;
#(
  parameter int unsigned ROW_W  = 5,
  parameter int unsigned ADDR_W = ROW_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  output logic [ROW_W-1:0]  row,
  output logic [LANES-1:0]  lane_mask
);
  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a, input logic w);
    return w ? a[ROW_W-1:0] : a[ADDR_W-1:1];
  endfunction

  function automatic logic [LANES-1:0] mask_of(input logic [ADDR_W-1:0] a, input logic w);
    logic [LANES-1:0] m;
    if (w) m = '1;
    else   m = LANES'(1) << a[0];
    return m;
  endfunction

  always_comb begin
    row       = row_of(addr, wide);
    lane_mask = mask_of(addr, wide);
  end
endmodule

// File: rtl/aspect_dpram_store.sv
`timescale 1ns/1ps
module aspect_dpram_store
  import aspect_dpram_pkg::*;
#(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned ROWS   = 32,
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned LW    = WORD_W / LANES
) (
  input  logic              wr_clk,
  input  logic [LANES-1:0]  lane_we,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [WORD_W-1:0] rd_word
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] lane_mem [ROWS];

    always_ff @(posedge wr_clk) begin
      if (lane_we[g]) lane_mem[wr_row] <= wr_word[g*LW +: LW];
    end

    assign rd_word[g*LW +: LW] = lane_mem[rd_row];
  end
endmodule

// File: rtl/aspect_dpram_rdstage.sv
`timescale 1ns/1ps
module aspect_dpram_rdstage
  import aspect_dpram_pkg::*;
#(
  parameter int unsigned WORD_W = 8,
  localparam int unsigned LW    = WORD_W / LANES
) (
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  input  logic              rd_hit,
  input  logic              wide,
  input  logic [LANES-1:0]  lane_mask,
  input  logic [WORD_W-1:0] row_word,
  output logic [WORD_W-1:0] rd_data
);
  function automatic logic [WORD_W-1:0] shape(input logic [WORD_W-1:0] w,
                                              input logic [LANES-1:0]  m,
                                              input logic              wd);
    logic [WORD_W-1:0] acc;
    acc = '0;
    if (wd) acc = w;
    else begin
      for (int g = 0; g < LANES; g++) begin
        if (m[g]) acc[LW-1:0] = acc[LW-1:0] | w[g*LW +: LW];
      end
    end
    return acc;
  endfunction

  logic [WORD_W-1:0] shaped;
  assign shaped = shape(row_word, lane_mask, wide);

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n)  rd_data <= '0;
    else if (rd_en) rd_data <= rd_hit ? shaped : '0;
  end
endmodule

// File: rtl/aspect_dpram.sv
`timescale 1ns/1ps
module aspect_dpram
  import aspect_dpram_pkg::*;
#(
  parameter int unsigned WORD_W   = 8,
  parameter int unsigned ROWS     = 32,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned BLOCK_ID = 0,
  localparam int unsigned ROW_W   = $clog2(ROWS),
  localparam int unsigned ADDR_W  = ROW_W + 1,
  localparam int unsigned LW      = WORD_W / LANES
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wide_mode
);
  localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(BLOCK_ID);

  org_e org;
  assign org = org_e'(wide_mode);
  logic wide;
  assign wide = (org == ORG_WIDE);

  // named events for the checker
  logic              wr_hit;
  logic              rd_hit;
  logic [LANES-1:0]  wr_lane_mask;
  logic [LANES-1:0]  wr_lane_we;
  logic [LANES-1:0]  rd_lane_mask;
  logic [ROW_W-1:0]  wr_row;
  logic [ROW_W-1:0]  rd_row;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] row_word;

  assign wr_hit     = wr_en && (wr_sel == MY_SEL);
  assign rd_hit     = (rd_sel == MY_SEL);
  assign wr_lane_we = wr_hit ? wr_lane_mask : '0;
  assign wr_word    = wide ? wr_data : {LANES{wr_data[LW-1:0]}};

  aspect_dpram_amap #(.ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_wmap (
    .addr(wr_addr), .wide(wide), .row(wr_row), .lane_mask(wr_lane_mask)
  );

  aspect_dpram_amap #(.ROW_W(ROW_W), .ADDR_W(ADDR_W)) u_rmap (
    .addr(rd_addr), .wide(wide), .row(rd_row), .lane_mask(rd_lane_mask)
  );

  aspect_dpram_store #(.WORD_W(WORD_W), .ROWS(ROWS)) u_store (
    .wr_clk(wr_clk), .lane_we(wr_lane_we), .wr_row(wr_row), .wr_word(wr_word),
    .rd_row(rd_row), .rd_word(row_word)
  );

  aspect_dpram_rdstage #(.WORD_W(WORD_W)) u_rd (
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_hit(rd_hit),
    .wide(wide), .lane_mask(rd_lane_mask), .row_word(row_word), .rd_data(rd_data)
  );
endmodule

// File: rtl/aspect_dpram_chk.sv
`timescale 1ns/1ps
module aspect_dpram_chk #(
  parameter int unsigned WORD_W   = 8,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned BLOCK_ID = 0,
  parameter int unsigned LANES    = 2
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input logic [SEL_W-1:0]  wr_sel,
  input logic              rd_en,
  input logic [SEL_W-1:0]  rd_sel,
  input logic              wide_mode,
  input logic [WORD_W-1:0] rd_data,
  input logic [LANES-1:0]  wr_lane_we
);
  localparam int unsigned LW = WORD_W / LANES;

  // R5
  rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_en |=> $stable(rd_data));

  // R8
  rd_desel_zero_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && rd_sel != SEL_W'(BLOCK_ID)) |=> (rd_data == '0));

  // R3
  narrow_upper_zero_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && !wide_mode) |=> (rd_data[WORD_W-1:LW] == '0));

  // R7
  wr_desel_quiet_chk: assert property (@(posedge wr_clk) disable iff (!rd_rst_n)
    (wr_sel != SEL_W'(BLOCK_ID)) |-> (wr_lane_we == '0));

  // R3
  narrow_one_lane_chk: assert property (@(posedge wr_clk) disable iff (!rd_rst_n)
    !wide_mode |-> $onehot0(wr_lane_we));
endmodule

bind aspect_dpram aspect_dpram_chk #(
  .WORD_W(WORD_W), .SEL_W(SEL_W), .BLOCK_ID(BLOCK_ID), .LANES(2)
) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .wr_sel(wr_sel),
  .rd_en(rd_en), .rd_sel(rd_sel), .wide_mode(wide_mode), .rd_data(rd_data),
  .wr_lane_we(wr_lane_we)
);

// File: tb/test_aspect_dpram.sv
`timescale 1ns/1ps
module test_aspect_dpram;
  localparam int ID = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 0, rd_en = 0, wide_mode = 1;
  logic [1:0] wr_sel = 0, rd_sel = 0;
  logic [5:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;

  always #5 clk = ~clk;

  aspect_dpram #(.WORD_W(8), .ROWS(32), .SEL_W(2), .BLOCK_ID(ID)) i_aspect_dpram (
    .wr_clk(clk), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel), .rd_addr(rd_addr),
    .rd_data(rd_data), .wide_mode(wide_mode)
  );

  int checks = 0, failures = 0;
  logic [7:0] model [32];

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_rd(input logic [5:0] a, input logic w);
    logic [7:0] b;
    if (w) return model[a % 32];
    b = model[a / 2];
    return (a % 2 == 1) ? {4'h0, b[7:4]} : {4'h0, b[3:0]};
  endfunction

  function automatic void model_wr(input logic [5:0] a, input logic [7:0] d, input logic w);
    if (w) model[a % 32] = d;
    else if (a % 2 == 1) model[a / 2][7:4] = d[3:0];
    else model[a / 2][3:0] = d[3:0];
  endfunction

  task automatic wr(input logic [5:0] a, input logic [7:0] d,
                    input logic [1:0] s = 2'(ID), input logic en = 1);
    @(negedge clk);
    wr_en = en; wr_sel = s; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (en && s == 2'(ID)) model_wr(a, d, wide_mode);
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] q, input logic [1:0] s = 2'(ID));
    @(negedge clk);
    rd_en = 1; rd_sel = s; rd_addr = a;
    @(negedge clk);
    rd_en = 0;
    q = rd_data;
  endtask

  task automatic t_reset();
    chk("R1 during reset", rd_data, 8'h00);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 after release", rd_data, 8'h00);
  endtask

  task automatic t_wide();
    logic [7:0] q;
    wide_mode = 1;
    wr(6'd3, 8'hA5); wr(6'd17, 8'h3C); wr(6'd31, 8'hFF);
    rd(6'd3, q);  chk("R2 row3", q, 8'hA5);
    rd(6'd17, q); chk("R2 row17", q, 8'h3C);
    rd(6'd35, q); chk("R2 addr bit5 ignored", q, 8'hA5);
    wr(6'd49, 8'h96);
    rd(6'd17, q); chk("R2 alias write", q, 8'h96);
  endtask

  task automatic t_narrow_layout();
    logic [7:0] q;
    wide_mode = 0;
    rd(6'd6, q); chk("R4 low nibble of row3", q, 8'h05);
    rd(6'd7, q); chk("R4 high nibble of row3", q, 8'h0A);
    wr(6'd7, 8'hF2);
    rd(6'd7, q); chk("R3 nibble written", q, 8'h02);
    rd(6'd6, q); chk("R3 neighbour nibble kept", q, 8'h05);
    wide_mode = 1;
    rd(6'd3, q); chk("R4 wide view of nibbles", q, 8'h25);
  endtask

  task automatic t_hold();
    logic [7:0] q;
    wide_mode = 1;
    rd(6'd17, q);
    @(negedge clk); rd_addr = 6'd3; rd_sel = 2'd0;
    wr(6'd17, 8'h11);
    @(negedge clk);
    chk("R5 hold while rd_en low", rd_data, 8'h96);
    @(negedge clk);
    rd_en = 1; rd_addr = 6'd17; rd_sel = 2'(ID);
    @(posedge clk); #1;
    chk("R5 one-edge latency", rd_data, 8'h11);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic t_collide();
    logic [7:0] q;
    wide_mode = 1;
    @(negedge clk);
    wr_en = 1; wr_sel = 2'(ID); wr_addr = 6'd9; wr_data = 8'h77;
    rd_en = 1; rd_sel = 2'(ID); rd_addr = 6'd9;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    chk("R6 old data on collision", rd_data, expect_rd(6'd9, 1'b1));
    model_wr(6'd9, 8'h77, 1'b1);
    rd(6'd9, q); chk("R6 new data afterwards", q, 8'h77);
  endtask

  task automatic t_ignored();
    logic [7:0] q;
    wide_mode = 1;
    wr(6'd4, 8'h5A);
    wr(6'd4, 8'hC3, 2'd1);
    rd(6'd4, q); chk("R7 deselected write ignored", q, 8'h5A);
    wr(6'd4, 8'hC3, 2'(ID), 1'b0);
    rd(6'd4, q); chk("R9 write disabled ignored", q, 8'h5A);
    rd(6'd4, q, 2'd3); chk("R8 deselected read zero", q, 8'h00);
    rd(6'd4, q); chk("R8 reselected read", q, 8'h5A);
  endtask

  task automatic t_fill();
    logic [7:0] q;
    wide_mode = 1;
    for (int i = 0; i < 32; i++) wr(6'(i), 8'((i * 37 + 11) & 8'hFF));
    for (int i = 0; i < 32; i++) begin
      rd(6'(i), q); chk("R10 wide fill", q, expect_rd(6'(i), 1'b1));
    end
    wide_mode = 0;
    for (int i = 0; i < 64; i++) wr(6'(i), 8'((i * 5 + 3) & 8'h0F));
    for (int i = 0; i < 64; i++) begin
      rd(6'(i), q); chk("R10 narrow fill", q, expect_rd(6'(i), 1'b0));
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    for (int i = 0; i < 32; i++) wr(6'(i), 8'h00);
    t_wide();
    t_narrow_layout();
    t_hold();
    t_collide();
    t_ignored();
    t_fill();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule